// File: doc/BRIEF.md
# Two-Controller Shared-Port Arbiter

This block lets two identical controllers take turns on one external memory port without any central arbiter. Each controller holds one instance. An instance drives an active-low request line and watches an active-low indication line, which is wired to the request line of the other instance. A strap input names one instance master and the other slave. The strap decides who wins when both ask at the same moment.

On the local side, the block takes a one-cycle `need_req` pulse when local logic wants the port, and a one-cycle `done` pulse when its transactions are finished. It returns a one-cycle `granted` pulse when ownership starts. It also returns a level `if_enable` that gates the local port drivers and lets the local execution engine run. While the peer holds the port, `if_enable` stays low and local work waits.

The indication input passes through a two-flop synchronizer. A request is only granted after the indication has been seen high for a full window of three clock edges while the local request is already driven low. This window is long enough that two instances can never both be granted at the same time. An indication input that is not used is tied high, and the block then behaves as a lone owner.

Top module: `peer_arbiter`

## Requirements
- R1: While `rst_n` is low and on the first edge after it, `req_n` is 1 and both `granted` and `if_enable` are 0. The synchronizer holds the "no peer request" value (1) out of reset.
- R2: A `need_req` pulse in the idle state drives `req_n` low after the edge that samples the pulse.
- R3: With `peer_req_n` held high, `if_enable` rises after the third edge following the one that lowered `req_n`. `granted` is 1 for exactly that first cycle of ownership.
- R4: While the synchronized indication is low, no grant is issued and the master keeps `req_n` low. After `peer_req_n` rises, the master's `if_enable` rises after the fifth edge, counting the first edge that samples the high level as the first.
- R5: If the indication falls on the same edge that samples the local `need_req`, the slave drives `req_n` high after the second edge from that one. After the indication returns high, counting from the first edge that samples it high, the slave drives `req_n` low again after the third edge and is granted after the sixth. The master in the same situation keeps `req_n` low throughout.
- R6: Once `if_enable` is 1, it stays 1 whatever `peer_req_n` does, until a `done` pulse. After the edge that samples `done`, `req_n` is 1 and `if_enable` is 0.
- R7: `done` has no effect unless the block owns the port. `need_req` has no effect unless the block is idle, so a pulse during ownership does not start a new request after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| is_master | input | 1 | Role strap: 1 = master, 0 = slave |
| need_req | input | 1 | One-cycle pulse: local side wants the shared port |
| done | input | 1 | One-cycle pulse: local transactions are complete |
| peer_req_n | input | 1 | Peer's request line, active low (tie high if unused) |
| req_n | output | 1 | Local request line to the peer, active low |
| granted | output | 1 | One-cycle pulse when ownership begins |
| if_enable | output | 1 | High while this side owns the shared port |

## Verification
The bench acts as the peer and drives the indication line against the block in both roles. The patterns are:
- A constantly high indication. This measures the bare grant window.
- An indication already low before the request. This separates deferral from a grant.
- An indication falling on the very edge of the request. This is the tie, and it separates the master, which holds its request, from the slave, which withdraws and then reasserts.
- The indication dropping during ownership. This shows that ownership is kept.

Stray `done` and `need_req` pulses are placed in the non-owning and owning states. Each is then checked at `req_n` and `if_enable` to show it has no effect.

// File: rtl/peer_arbiter.sv
module peer_arbiter #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_master,
  input  logic need_req,
  input  logic done,
  input  logic peer_req_n,
  output logic req_n,
  output logic granted,
  output logic if_enable
);

  localparam int WAIT_LEN = SYNC_LEN + 1;
  localparam int CW = $clog2(WAIT_LEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_WANT, S_OWN, S_YIELD} st_t;

  st_t state;
  logic [SYNC_LEN-1:0] sync_q;
  logic [CW-1:0] cnt;
  logic peer_s, win;

  // two-flop style synchronizer, idle value means "no peer request"
  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_LEN-2:0], peer_req_n};
  end

  assign peer_s = sync_q[SYNC_LEN-1];
  assign win    = (state == S_WANT) && peer_s && (cnt == CW'(WAIT_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      granted <= 1'b0;
    end else begin
      granted <= win;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (need_req) state <= S_WANT;
        end
        S_WANT: begin
          if (!peer_s) begin
            cnt <= '0;
            if (!is_master) state <= S_YIELD;
          end else if (win) begin
            cnt   <= '0;
            state <= S_OWN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_OWN: begin
          cnt <= '0;
          if (done) state <= S_IDLE;
        end
        default: begin
          cnt <= '0;
          if (peer_s) state <= S_WANT;
        end
      endcase
    end
  end

  assign req_n     = !((state == S_WANT) || (state == S_OWN));
  assign if_enable = (state == S_OWN);

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (req_n && !granted && !if_enable));

  a_r2_own_implies_request: assert property (@(posedge clk) disable iff (!rst_n)
    if_enable |-> !req_n);

  a_r3_grant_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    granted |=> !granted);

  a_r3_grant_marks_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_enable) |-> granted);

  a_r4_no_grant_on_peer_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_WANT) && !peer_s) |=> !if_enable);

  a_r5_slave_yields: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_WANT) && !peer_s && !is_master) |=> req_n);

  a_r5_master_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_WANT) && !peer_s && is_master) |=> !req_n);

  a_r6_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (if_enable && !done) |=> if_enable);

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (if_enable && done) |=> (req_n && !if_enable));

  a_r7_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_enable && !req_n && done) |=> !req_n);

endmodule

// File: tb/test_peer_arbiter.sv
module test_peer_arbiter;
  logic clk = 1'b0;
  logic rst_n, is_master, need_req, done, peer_req_n;
  logic req_n, granted, if_enable;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  peer_arbiter i_peer_arbiter (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .need_req(need_req),
    .done(done), .peer_req_n(peer_req_n), .req_n(req_n), .granted(granted),
    .if_enable(if_enable)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic start(input logic master);
    rst_n = 1'b0; is_master = master; need_req = 1'b0; done = 1'b0; peer_req_n = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic pulse_need();
    need_req = 1'b1; step(1); need_req = 1'b0;
  endtask

  task automatic pulse_done();
    done = 1'b1; step(1); done = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; is_master = 1'b1; need_req = 1'b1; done = 1'b0; peer_req_n = 1'b0;
    step(2);
    chk("R1 req_n in reset", req_n, 1'b1);
    chk("R1 if_enable in reset", if_enable, 1'b0);
    chk("R1 granted in reset", granted, 1'b0);
    start(1'b1);
    chk("R1 req_n after reset", req_n, 1'b1);
  endtask

  task automatic t_solo(input logic master);
    start(master);
    pulse_need();
    chk("R2 req_n low after need", req_n, 1'b0);
    step(2);
    chk("R3 no enable before window", if_enable, 1'b0);
    step(1);
    chk("R3 enable after window", if_enable, 1'b1);
    chk("R3 granted pulse", granted, 1'b1);
    step(1);
    chk("R3 granted one cycle", granted, 1'b0);
    pulse_done();
    chk("R6 req_n released", req_n, 1'b1);
    chk("R6 enable dropped", if_enable, 1'b0);
  endtask

  task automatic t_tie_master();
    start(1'b1);
    need_req = 1'b1; peer_req_n = 1'b0; step(1); need_req = 1'b0;
    step(4);
    chk("R5 master keeps request", req_n, 1'b0);
    chk("R4 master deferred", if_enable, 1'b0);
    peer_req_n = 1'b1;
    step(4);
    chk("R4 no enable before fifth edge", if_enable, 1'b0);
    step(1);
    chk("R4 enable at fifth edge", if_enable, 1'b1);
    peer_req_n = 1'b0;
    step(6);
    chk("R6 ownership kept with peer low", if_enable, 1'b1);
    pulse_done();
    chk("R6 released after done", if_enable, 1'b0);
    peer_req_n = 1'b1;
  endtask

  task automatic t_tie_slave();
    start(1'b0);
    need_req = 1'b1; peer_req_n = 1'b0; step(1); need_req = 1'b0;
    chk("R5 slave request driven", req_n, 1'b0);
    step(1);
    chk("R5 slave still requesting", req_n, 1'b0);
    step(1);
    chk("R5 slave withdraws", req_n, 1'b1);
    step(5);
    chk("R5 slave stays withdrawn", req_n, 1'b1);
    chk("R5 slave not enabled", if_enable, 1'b0);
    peer_req_n = 1'b1;
    step(2);
    chk("R5 slave not yet reasserted", req_n, 1'b1);
    step(1);
    chk("R5 slave reasserts", req_n, 1'b0);
    step(2);
    chk("R5 slave not yet enabled", if_enable, 1'b0);
    step(1);
    chk("R5 slave enabled", if_enable, 1'b1);
  endtask

  task automatic t_ignore();
    start(1'b1);
    pulse_done();
    chk("R7 done in idle keeps req_n", req_n, 1'b1);
    chk("R7 done in idle keeps enable", if_enable, 1'b0);
    peer_req_n = 1'b0;
    step(3);
    pulse_need();
    step(2);
    pulse_done();
    step(3);
    chk("R7 done while waiting ignored", req_n, 1'b0);
    chk("R4 no grant while peer low", if_enable, 1'b0);
    peer_req_n = 1'b1;
    step(5);
    chk("R4 grant after peer release", if_enable, 1'b1);
    pulse_need();
    pulse_done();
    step(4);
    chk("R7 need during ownership ignored", req_n, 1'b1);
    chk("R7 no enable after release", if_enable, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_solo(1'b1);
    t_solo(1'b0);
    t_tie_master();
    t_tie_slave();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule